// File: doc/BRIEF.md
# Speculative L1 Dependency Tracker

This block keeps the speculation state for the lines of a small write-through L1 data cache. The cache belongs to one core of a four-core multiprocessor that runs threads speculatively. For every line it tracks a valid bit, a modified bit and a pre-invalidate bit. For every byte of every line it also tracks a read bit and a write bit. Local loads and stores arrive with a line index and a byte mask, and the block updates the matching bits.

The block also watches a shared write bus. Each snooped write carries a line index, a byte mask and the speculation rank of the core that wrote it. A lower rank means an older, less speculative thread.

- A write from an older thread that lands on a byte this thread has already consumed raises a sticky violation flag. The recovery software reacts to that flag.
- A write from a younger thread does not raise a violation. It marks the line for pre-invalidation, and the line is dropped when the thread finishes.
- A done pulse ends the thread. In a single cycle it invalidates every marked line and clears all speculation state.

Stores are forwarded toward the shared write path through a valid/ready pass-through. A store counts as accepted, and updates the tracking bits, only in a cycle where both `st_valid` and `st_ready` are high. `st_ready` follows `wt_ready` in the same cycle, so back-pressure from the write path stalls the core's store directly. The line data itself, refill and the recovery handler are outside this block. A local access to a line is treated as bringing that line in, so the access sets the line's valid bit.

Top module: `spec_dep_tracker`

## Requirements
- R1: After reset, every valid, modified, pre-invalidate, read and write bit is 0, and `violation` is 0.
- R2: A load (`ld_valid`) sets the line's valid bit one cycle later. For each byte in `ld_mask`, it also sets that byte's read bit, but only if the byte's write bit was clear before the cycle.
- R3: An accepted store (`st_valid` and `st_ready`) sets the write bit of each byte in `st_mask`, and sets the line's modified and valid bits, one cycle later. A store that is not accepted changes no state.
- R4: A load of a byte whose write bit is already set leaves that byte's read bit at 0. This holds when the load arrives in any cycle after the store was accepted.
- R5: A snooped write with `snp_rank` greater than `my_rank` to a valid line sets that line's pre-invalidate bit one cycle later. It does not raise `violation`. The pre-invalidate bit stays set until a done pulse.
- R6: A snooped write with `snp_rank` less than `my_rank` raises `violation` one cycle later if it hits a byte whose read bit is set and whose write bit is clear. `violation` then stays high until a done pulse. A hit only on bytes whose write bit is set does not raise it.
- R7: On `done`, one cycle later: every line with pre-invalidate set becomes invalid, and all read, write, modified and pre-invalidate bits are 0. `violation` is 0 as well. Loads, stores and snoops presented in the done cycle change no tracking state.
- R8: In the same cycle, `wt_valid`, `wt_line` and `wt_mask` mirror `st_valid`, `st_line` and `st_mask`, and `st_ready` equals `wt_ready`.
- R9: A snooped write with `snp_rank` equal to `my_rank` changes no state.
- R10: Bit layout: line i, byte b maps to bit i*16+b of `rd_bits` and `wr_bits`. Bit i of the per-line vectors is line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| my_rank | input | 2 | Speculation rank of this core's thread (0 = least speculative) |
| ld_valid | input | 1 | Local load this cycle |
| ld_line | input | 3 | Line index of the load |
| ld_mask | input | 16 | Bytes read by the load |
| st_valid | input | 1 | Local store offered |
| st_ready | output | 1 | Store accepted by the write path |
| st_line | input | 3 | Line index of the store |
| st_mask | input | 16 | Bytes written by the store |
| wt_valid | output | 1 | Write-through request toward the shared write path |
| wt_ready | input | 1 | Shared write path can take the request |
| wt_line | output | 3 | Line index of the write-through |
| wt_mask | output | 16 | Byte mask of the write-through |
| snp_valid | input | 1 | Snooped write on the shared bus |
| snp_rank | input | 2 | Rank of the writing core |
| snp_line | input | 3 | Line index of the snooped write |
| snp_mask | input | 16 | Bytes written by the snooped write |
| done | input | 1 | Thread finished; resolve and clear speculation state |
| violation | output | 1 | Sticky dependency violation flag |
| line_valid | output | 8 | Valid bit per line |
| line_mod | output | 8 | Modified bit per line |
| line_preinv | output | 8 | Pre-invalidate bit per line |
| rd_bits | output | 128 | Read bit per byte, flattened |
| wr_bits | output | 128 | Write bit per byte, flattened |

## Verification
On every clock, the assertions check these rules:
- No read bit is newly set on a byte whose write bit was already set.
- A done pulse always empties the speculation state.
- Pre-invalidate bits and the violation flag hold until done.
- A conflicting older write always raises the violation flag.

Some behaviour only the bench's scenarios can show, using its cycle-by-cycle reference model:
- The exact byte selection and the line-index decoding.
- The rank comparison that separates older writers from younger ones and from the thread's own rank.
- That a stalled store leaves no trace in the state.
- That the valid bit is dropped only on lines that were marked for pre-invalidation.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;
  parameter int unsigned DEF_LINES      = 8;
  parameter int unsigned DEF_LINE_BYTES = 16;
  parameter int unsigned DEF_RANK_W     = 2;

  // Relative age of a snooped writer versus the local thread.
  typedef enum logic [1:0] {
    WR_SAME    = 2'd0,
    WR_OLDER   = 2'd1,
    WR_YOUNGER = 2'd2
  } writer_age_e;

  function automatic writer_age_e classify_writer(input logic [7:0] writer, input logic [7:0] self);
    if (writer < self)      return WR_OLDER;
    else if (writer > self) return WR_YOUNGER;
    else                    return WR_SAME;
  endfunction
endpackage

// File: rtl/spec_line_state.sv
module spec_line_state #(
  parameter int unsigned NB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic          ld_hit_i,
  input  logic [NB-1:0] ld_mask_i,
  input  logic          st_hit_i,
  input  logic [NB-1:0] st_mask_i,
  input  logic          snp_old_i,
  input  logic          snp_young_i,
  input  logic [NB-1:0] snp_mask_i,
  output logic          valid_o,
  output logic          mod_o,
  output logic          preinv_o,
  output logic [NB-1:0] rd_o,
  output logic [NB-1:0] wr_o,
  output logic          conflict_o
);
  logic          valid_q, mod_q, preinv_q;
  logic [NB-1:0] rd_q, wr_q;
  logic [NB-1:0] rd_new;

  // Bytes already written locally are private copies: no dependency.
  assign rd_new     = ld_hit_i ? (ld_mask_i & ~wr_q) : '0;
  assign conflict_o = snp_old_i && ((snp_mask_i & rd_q & ~wr_q) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      mod_q    <= 1'b0;
      preinv_q <= 1'b0;
      rd_q     <= '0;
      wr_q     <= '0;
    end else if (done_i) begin
      if (preinv_q) valid_q <= 1'b0;
      mod_q    <= 1'b0;
      preinv_q <= 1'b0;
      rd_q     <= '0;
      wr_q     <= '0;
    end else begin
      rd_q <= rd_q | rd_new;
      if (st_hit_i) begin
        wr_q  <= wr_q | st_mask_i;
        mod_q <= 1'b1;
      end
      if (ld_hit_i || st_hit_i) valid_q <= 1'b1;
      if (snp_young_i && valid_q) preinv_q <= 1'b1;
    end
  end

  assign valid_o  = valid_q;
  assign mod_o    = mod_q;
  assign preinv_o = preinv_q;
  assign rd_o     = rd_q;
  assign wr_o     = wr_q;

  // R4: a newly set read bit never lands on a byte that was already written
  a_r4_no_dep_on_own_write: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> ((rd_q & ~$past(rd_q) & $past(wr_q)) == '0));
  // R7: done leaves the line free of speculation state
  a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (rd_q == '0 && wr_q == '0 && !mod_q && !preinv_q));
  // R5: pre-invalidate persists until done
  a_r5_preinv_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (preinv_q && !done_i) |=> preinv_q);
endmodule

// File: rtl/spec_viol_unit.sv
module spec_viol_unit #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done_i,
  input  logic [N-1:0] conflict_i,
  output logic         violation_o
);
  logic viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           viol_q <= 1'b0;
    else if (done_i)      viol_q <= 1'b0;
    else if (|conflict_i) viol_q <= 1'b1;
  end

  assign violation_o = viol_q;

  // R6: flag is sticky until the thread finishes
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_q && !done_i) |=> viol_q);
  // R6: any conflicting older write raises the flag
  a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ((|conflict_i) && !done_i) |=> viol_q);
  // R7: done clears the flag
  a_r7_done_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !viol_q);
endmodule

// File: rtl/spec_wt_port.sv
module spec_wt_port #(
  parameter int unsigned IW = 3,
  parameter int unsigned NB = 16
) (
  input  logic          st_valid_i,
  output logic          st_ready_o,
  input  logic [IW-1:0] st_line_i,
  input  logic [NB-1:0] st_mask_i,
  output logic          wt_valid_o,
  input  logic          wt_ready_i,
  output logic [IW-1:0] wt_line_o,
  output logic [NB-1:0] wt_mask_o,
  output logic          accept_o
);
  // Write-through: every store is forwarded, back-pressure flows straight back.
  assign wt_valid_o = st_valid_i;
  assign wt_line_o  = st_line_i;
  assign wt_mask_o  = st_mask_i;
  assign st_ready_o = wt_ready_i;
  assign accept_o   = st_valid_i && wt_ready_i;
endmodule

// File: rtl/spec_dep_tracker.sv
module spec_dep_tracker
  import spec_trk_pkg::*;
#(
  parameter int unsigned LINES      = DEF_LINES,
  parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
  parameter int unsigned RANK_W     = DEF_RANK_W,
  localparam int unsigned IW        = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int unsigned TOTAL_B   = LINES * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [RANK_W-1:0]     my_rank,
  input  logic                  ld_valid,
  input  logic [IW-1:0]         ld_line,
  input  logic [LINE_BYTES-1:0] ld_mask,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [IW-1:0]         st_line,
  input  logic [LINE_BYTES-1:0] st_mask,
  output logic                  wt_valid,
  input  logic                  wt_ready,
  output logic [IW-1:0]         wt_line,
  output logic [LINE_BYTES-1:0] wt_mask,
  input  logic                  snp_valid,
  input  logic [RANK_W-1:0]     snp_rank,
  input  logic [IW-1:0]         snp_line,
  input  logic [LINE_BYTES-1:0] snp_mask,
  input  logic                  done,
  output logic                  violation,
  output logic [LINES-1:0]      line_valid,
  output logic [LINES-1:0]      line_mod,
  output logic [LINES-1:0]      line_preinv,
  output logic [TOTAL_B-1:0]    rd_bits,
  output logic [TOTAL_B-1:0]    wr_bits
);
  logic             st_accept;
  logic             snp_is_old, snp_is_young;
  logic [LINES-1:0] conflict;
  writer_age_e      age;

  spec_wt_port #(.IW(IW), .NB(LINE_BYTES)) u_wt (
    .st_valid_i (st_valid),
    .st_ready_o (st_ready),
    .st_line_i  (st_line),
    .st_mask_i  (st_mask),
    .wt_valid_o (wt_valid),
    .wt_ready_i (wt_ready),
    .wt_line_o  (wt_line),
    .wt_mask_o  (wt_mask),
    .accept_o   (st_accept)
  );

  always_comb begin
    age          = classify_writer(8'(snp_rank), 8'(my_rank));
    snp_is_old   = snp_valid && (age == WR_OLDER);
    snp_is_young = snp_valid && (age == WR_YOUNGER);
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic ld_sel, st_sel, sn_sel;
    assign ld_sel = ld_valid  && (ld_line  == IW'(i));
    assign st_sel = st_accept && (st_line  == IW'(i));
    assign sn_sel = (snp_line == IW'(i));

    spec_line_state #(.NB(LINE_BYTES)) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_i      (done),
      .ld_hit_i    (ld_sel),
      .ld_mask_i   (ld_mask),
      .st_hit_i    (st_sel),
      .st_mask_i   (st_mask),
      .snp_old_i   (snp_is_old && sn_sel),
      .snp_young_i (snp_is_young && sn_sel),
      .snp_mask_i  (snp_mask),
      .valid_o     (line_valid[i]),
      .mod_o       (line_mod[i]),
      .preinv_o    (line_preinv[i]),
      .rd_o        (rd_bits[i*LINE_BYTES +: LINE_BYTES]),
      .wr_o        (wr_bits[i*LINE_BYTES +: LINE_BYTES]),
      .conflict_o  (conflict[i])
    );
  end

  spec_viol_unit #(.N(LINES)) u_viol (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_i      (done),
    .conflict_i  (conflict),
    .violation_o (violation)
  );

  // R3: a stalled store leaves the write bits untouched
  a_r3_stalled_store_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (!(st_valid && wt_ready) && !done) |=> ($past(wr_bits) == wr_bits));
  // R9: own-rank snoop never raises the flag by itself
  a_r9_same_rank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!violation && snp_valid && snp_rank == my_rank && !done) |=> !violation);
endmodule

// File: tb/spec_dep_tracker_tb.sv
module spec_dep_tracker_tb_top;
  localparam int L = 8;
  localparam int B = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  my_rank = 2'd2;
  logic        ld_valid = 0, st_valid = 0, wt_ready = 0, snp_valid = 0, done = 0;
  logic [2:0]  ld_line = 0, st_line = 0, snp_line = 0;
  logic [15:0] ld_mask = 0, st_mask = 0, snp_mask = 0;
  logic [1:0]  snp_rank = 0;
  logic        st_ready, wt_valid, violation;
  logic [2:0]  wt_line;
  logic [15:0] wt_mask;
  logic [7:0]  line_valid, line_mod, line_preinv;
  logic [127:0] rd_bits, wr_bits;

  spec_dep_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .my_rank(my_rank),
    .ld_valid(ld_valid), .ld_line(ld_line), .ld_mask(ld_mask),
    .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line), .st_mask(st_mask),
    .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_line(wt_line), .wt_mask(wt_mask),
    .snp_valid(snp_valid), .snp_rank(snp_rank), .snp_line(snp_line), .snp_mask(snp_mask),
    .done(done), .violation(violation),
    .line_valid(line_valid), .line_mod(line_mod), .line_preinv(line_preinv),
    .rd_bits(rd_bits), .wr_bits(wr_bits)
  );

  int checks = 0;
  int failures = 0;

  // Behavioural reference state
  logic [15:0] m_rd [L];
  logic [15:0] m_wr [L];
  logic        m_val [L];
  logic        m_mod [L];
  logic        m_pre [L];
  logic        m_viol;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [127:0] e_rd, e_wr;
    logic [7:0]   e_v, e_m, e_p;
    for (int i = 0; i < L; i++) begin
      e_rd[i*B +: B] = m_rd[i];
      e_wr[i*B +: B] = m_wr[i];
      e_v[i] = m_val[i]; e_m[i] = m_mod[i]; e_p[i] = m_pre[i];
    end
    chk(rd_bits == e_rd, "R2/R4/R10", "rd_bits", rd_bits, e_rd);
    chk(wr_bits == e_wr, "R3/R10", "wr_bits", wr_bits, e_wr);
    chk(line_valid == e_v, "R7", "line_valid", 128'(line_valid), 128'(e_v));
    chk(line_mod == e_m, "R3", "line_mod", 128'(line_mod), 128'(e_m));
    chk(line_preinv == e_p, "R5", "line_preinv", 128'(line_preinv), 128'(e_p));
    chk(violation == m_viol, "R6", "violation", 128'(violation), 128'(m_viol));
  endtask

  task automatic model_step();
    logic [15:0] o_rd [L];
    logic [15:0] o_wr [L];
    logic        o_val [L];
    logic        acc;
    for (int i = 0; i < L; i++) begin
      o_rd[i] = m_rd[i]; o_wr[i] = m_wr[i]; o_val[i] = m_val[i];
    end
    acc = st_valid && wt_ready;
    if (done) begin
      for (int i = 0; i < L; i++) begin
        if (m_pre[i]) m_val[i] = 1'b0;
        m_rd[i] = '0; m_wr[i] = '0; m_mod[i] = 1'b0; m_pre[i] = 1'b0;
      end
      m_viol = 1'b0;
    end else begin
      if (snp_valid && snp_rank < my_rank &&
          ((snp_mask & o_rd[snp_line] & ~o_wr[snp_line]) != 0)) m_viol = 1'b1;
      if (snp_valid && snp_rank > my_rank && o_val[snp_line]) m_pre[snp_line] = 1'b1;
      if (ld_valid) begin
        m_rd[ld_line] = m_rd[ld_line] | (ld_mask & ~o_wr[ld_line]);
        m_val[ld_line] = 1'b1;
      end
      if (acc) begin
        m_wr[st_line] = m_wr[st_line] | st_mask;
        m_mod[st_line] = 1'b1;
        m_val[st_line] = 1'b1;
      end
    end
  endtask

  task automatic idle_inputs();
    ld_valid = 0; st_valid = 0; snp_valid = 0; done = 0; wt_ready = 1;
  endtask

  // Inputs are set at negedge; model advances on the following posedge.
  task automatic step();
    #1;
    // R8: write-through mirrors the store request in the same cycle
    chk(wt_valid == st_valid && wt_line == st_line && wt_mask == st_mask && st_ready == wt_ready,
        "R8", "wt_path", {wt_valid, wt_line, wt_mask, st_ready}, {st_valid, st_line, st_mask, wt_ready});
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic do_ld(input int ln, input logic [15:0] m);
    ld_valid = 1; ld_line = 3'(ln); ld_mask = m;
  endtask
  task automatic do_st(input int ln, input logic [15:0] m, input bit rdy);
    st_valid = 1; st_line = 3'(ln); st_mask = m; wt_ready = rdy;
  endtask
  task automatic do_snp(input int ln, input int rk, input logic [15:0] m);
    snp_valid = 1; snp_line = 3'(ln); snp_rank = 2'(rk); snp_mask = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < L; i++) begin
      m_rd[i] = 0; m_wr[i] = 0; m_val[i] = 0; m_mod[i] = 0; m_pre[i] = 0;
    end
    m_viol = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all();
    rst_n = 1;
    @(negedge clk);
    compare_all();

    // R2: load sets read bits and valid
    do_ld(1, 16'h00F0); step();
    // R3: stalled store has no effect, accepted store does
    do_st(2, 16'h000F, 0); step();
    do_st(2, 16'h000F, 1); step();
    // R4: load of written bytes records no dependency
    do_ld(2, 16'h00FF); step();
    // R6: older write to a written-only byte -> no violation
    do_snp(2, 1, 16'h0003); step();
    // R9: same-rank snoop on read byte has no effect
    do_snp(1, 2, 16'h0010); step();
    // R5: younger write pre-invalidates valid line 1, no violation
    do_snp(1, 3, 16'h0010); step();
    // R5: younger write to invalid line 5 sets nothing
    do_snp(5, 3, 16'hFFFF); step();
    // R6: older write to read byte raises violation, which stays
    do_snp(1, 0, 16'h0020); step();
    step(); step();
    // R7: done drops pre-invalidated line 1, keeps line 2, clears all
    done = 1; do_ld(3, 16'h1); do_st(4, 16'h1, 1); do_snp(2, 0, 16'hFFFF); step();
    step();

    // Mixed traffic against the reference model
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[0]) do_ld(int'(r[3:1]), 16'($urandom));
      if (r[4]) do_st(int'(r[7:5]), 16'($urandom), r[8]);
      else wt_ready = r[8];
      if (r[9]) do_snp(int'(r[12:10]), int'(r[14:13]), 16'($urandom));
      done = (r[21:16] == 6'd0);
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule